// File: doc/BRIEF.md
# Configuration Image Stream Loader

This block turns a configuration image, delivered one byte at a time over a valid/ready handshake, into a series of register write transactions. An image opens with a two-byte format marker and a block count. After that come one or more blocks, each with a four-byte header that packs a word count and a 22-bit start address, followed by that block's data words. The image closes with a two-byte checksum. The byte source is typically a serial-memory reader. The register file sits on the write port and acknowledges each write.

Registers may be 32 bits or 8 bits wide. A side input reports the width of the register currently addressed. The loader samples it when a word begins and takes four bytes or one byte to match. Consecutive words of a block go to consecutive addresses. A bad marker byte stops the load at once and no writes are issued. A checksum mismatch is reported together with completion. A start pulse begins a new load from the first marker byte at any time.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset, `in_ready`, `wr_en`, `done`, `error` and `abort` are low, and no byte is accepted until `start` is pulsed.
- R2: Image bytes 0 and 1 must each equal 0xAA. If either differs, `abort` rises in the next cycle, `in_ready` stays low, `done` stays low, and no write is issued.
- R3: Bytes 2 (low) and 3 (high) hold the block count minus one. The loader processes exactly that many plus one blocks, then reads the two checksum bytes.
- R4: Each block header carries the word count minus one as 10 bits. Bits 7:0 are in header byte 0 and bits 9:8 are in bits 1:0 of header byte 1, so a block may hold up to 1024 words.
- R5: Each block's start address takes bits 5:0 from header byte 1 bits 7:2, bits 13:6 from header byte 2, and bits 21:14 from header byte 3. `wr_addr[23:22]` is always zero.
- R6: A 32-bit word is assembled from four bytes, least significant byte first. Each further word of a block targets the previous address plus one, modulo 2^22.
- R7: `reg_narrow` is sampled on the first byte of each word. When it is high, that single byte forms the write (`wr_data` = {24'h0, byte}, `wr_byte` = 1), and the next byte starts the next word.
- R8: `wr_en` stays high, with `wr_addr`, `wr_data` and `wr_byte` stable, until the cycle in which `wr_ack` is high. `in_ready` is low whenever `wr_en` is high, so no byte is lost.
- R9: The checksum is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first over every byte before the checksum. The checksum is sent low byte first. After the second checksum byte, `done` goes high, `error` goes high on a mismatch, and `in_ready` goes low.
- R10: A `start` pulse in any state clears `done`, `error` and `abort` and restarts parsing at the first marker byte. `in_ready` is low during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new load from the first marker byte |
| in_valid | input | 1 | Image byte valid |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Loader accepts the byte this cycle |
| reg_narrow | input | 1 | Register at `wr_addr` is 8 bits wide |
| wr_en | output | 1 | Register write request, held until acknowledged |
| wr_addr | output | 24 | Register address (current target while assembling) |
| wr_data | output | 32 | Register write data |
| wr_byte | output | 1 | Write targets an 8-bit register |
| wr_ack | input | 1 | Register port accepts the pending write |
| done | output | 1 | Image fully consumed |
| error | output | 1 | Checksum mismatch (valid with `done`) |
| abort | output | 1 | Load stopped on a bad marker byte |

## Verification
A header field captured into the wrong counter or bit position shows up at the port on the first write of the affected block. That write either lands at a wrong address, or the write count differs from the image's. A word counter that is off by one shifts every later byte of the stream. That misaligns data on the next write and leaves `done` either never rising or rising with `error`. The checksum therefore exposes any byte-framing fault by the end of the image at the latest. A fault in the write handshake or in the ready gating shows within a cycle of the write request, as a changed address or data while `wr_en` is held, or as a byte accepted during a pending write.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 22;
    localparam int BUS_ADDR_W = 24;
    localparam int DATA_W     = 32;
    localparam int WCNT_W     = 10;
    localparam int BCNT_W     = 16;
    localparam int CRC_W      = 16;

    localparam logic [BYTE_W-1:0] VER_MARK  = 8'hAA;
    localparam logic [CRC_W-1:0]  CRC_POLY  = 16'h1021;
    localparam logic [CRC_W-1:0]  CRC_SEED  = 16'hFFFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VER0,
        ST_VER1,
        ST_CNT0,
        ST_CNT1,
        ST_HDR0,
        ST_HDR1,
        ST_HDR2,
        ST_HDR3,
        ST_DATA,
        ST_WRITE,
        ST_CRC0,
        ST_CRC1,
        ST_DONE,
        ST_ABORT
    } ldr_state_e;

    // Which header field the current byte feeds
    typedef enum logic [2:0] {
        HF_NONE,
        HF_BCNT_LO,
        HF_BCNT_HI,
        HF_WCNT_LO,
        HF_MIXED,
        HF_ADDR_MID,
        HF_ADDR_HI
    } hdr_field_e;

    typedef struct packed {
        logic [BCNT_W-1:0] blocks_left;
        logic [WCNT_W-1:0] words_left;
        logic [ADDR_W-1:0] addr;
    } walk_t;

    // One byte of a CRC-16, MSB first
    function automatic logic [CRC_W-1:0] crc_byte_upd(
        input logic [CRC_W-1:0]  c,
        input logic [BYTE_W-1:0] b,
        input logic [CRC_W-1:0]  poly
    );
        logic [CRC_W-1:0] r;
        r = c ^ {b, {(CRC_W-BYTE_W){1'b0}}};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_ldr_crc16.sv
module cfg_ldr_crc16
    import cfg_ldr_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY,
    parameter logic [CRC_W-1:0] SEED = CRC_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc <= SEED;
        end else if (en) begin
            crc <= crc_byte_upd(crc, din, POLY);
        end
    end

endmodule

// File: rtl/cfg_ldr_word_asm.sv
module cfg_ldr_word_asm
    import cfg_ldr_pkg::*;
#(
    parameter int WORD_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    input  logic              narrow,
    output logic [WORD_W-1:0] word,
    output logic              narrow_q,
    output logic              word_done
);

    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    logic [IDX_W-1:0] idx;
    logic             first;
    logic             eff_narrow;

    assign first      = (idx == '0);
    assign eff_narrow = first ? narrow : narrow_q;
    assign word_done  = take && (eff_narrow || (idx == LAST_IDX));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx      <= '0;
            word     <= '0;
            narrow_q <= 1'b0;
        end else if (take) begin
            if (first) begin
                // first byte clears upper lanes so an 8-bit write is zero-extended
                word     <= WORD_W'(din);
                narrow_q <= narrow;
            end else begin
                word[idx*BYTE_W +: BYTE_W] <= din;
            end
            idx <= word_done ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_ldr_walker.sv
module cfg_ldr_walker
    import cfg_ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cap,
    input  hdr_field_e        sel,
    input  logic [BYTE_W-1:0] din,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last_word,
    output logic              last_block
);

    walk_t w;

    assign addr       = w.addr;
    assign last_word  = (w.words_left == '0);
    assign last_block = (w.blocks_left == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            w <= '0;
        end else if (cap) begin
            unique case (sel)
                HF_BCNT_LO:  w.blocks_left[7:0]  <= din;
                HF_BCNT_HI:  w.blocks_left[15:8] <= din;
                HF_WCNT_LO:  w.words_left[7:0]   <= din;
                HF_MIXED: begin
                    w.words_left[9:8] <= din[1:0];
                    w.addr[5:0]       <= din[7:2];
                end
                HF_ADDR_MID: w.addr[13:6]  <= din;
                HF_ADDR_HI:  w.addr[21:14] <= din;
                default: ;
            endcase
        end else if (step) begin
            if (!last_word) begin
                w.words_left <= w.words_left - 1'b1;
                w.addr       <= w.addr + 1'b1;
            end else if (!last_block) begin
                w.blocks_left <= w.blocks_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import cfg_ldr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  in_valid,
    input  logic [BYTE_W-1:0]     in_data,
    output logic                  in_ready,
    input  logic                  reg_narrow,
    output logic                  wr_en,
    output logic [BUS_ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  wr_byte,
    input  logic                  wr_ack,
    output logic                  done,
    output logic                  error,
    output logic                  abort
);

    ldr_state_e        st, st_nx;
    hdr_field_e        sel;
    logic              rdy_st;
    logic              acc;
    logic              cap;
    logic              crc_en;
    logic              take;
    logic              word_done;
    logic              step;
    logic              last_word;
    logic              last_block;
    logic [ADDR_W-1:0] addr;
    logic [CRC_W-1:0]  crc;
    logic [BYTE_W-1:0] crc_lo;
    logic              bad_mark;

    always_comb begin
        unique case (st)
            ST_VER0, ST_VER1, ST_CNT0, ST_CNT1,
            ST_HDR0, ST_HDR1, ST_HDR2, ST_HDR3,
            ST_DATA, ST_CRC0, ST_CRC1: rdy_st = 1'b1;
            default:                   rdy_st = 1'b0;
        endcase
    end

    assign in_ready = rdy_st && !start;
    assign acc      = in_valid && in_ready;
    assign bad_mark = (in_data != VER_MARK);

    always_comb begin
        unique case (st)
            ST_CNT0: sel = HF_BCNT_LO;
            ST_CNT1: sel = HF_BCNT_HI;
            ST_HDR0: sel = HF_WCNT_LO;
            ST_HDR1: sel = HF_MIXED;
            ST_HDR2: sel = HF_ADDR_MID;
            ST_HDR3: sel = HF_ADDR_HI;
            default: sel = HF_NONE;
        endcase
    end

    assign cap    = acc && (sel != HF_NONE);
    assign take   = acc && (st == ST_DATA);
    assign crc_en = acc && (st != ST_CRC0) && (st != ST_CRC1);
    assign step   = (st == ST_WRITE) && wr_ack;

    always_comb begin
        st_nx = st;
        if (start) begin
            st_nx = ST_VER0;
        end else begin
            unique case (st)
                ST_VER0: if (acc) st_nx = bad_mark ? ST_ABORT : ST_VER1;
                ST_VER1: if (acc) st_nx = bad_mark ? ST_ABORT : ST_CNT0;
                ST_CNT0: if (acc) st_nx = ST_CNT1;
                ST_CNT1: if (acc) st_nx = ST_HDR0;
                ST_HDR0: if (acc) st_nx = ST_HDR1;
                ST_HDR1: if (acc) st_nx = ST_HDR2;
                ST_HDR2: if (acc) st_nx = ST_HDR3;
                ST_HDR3: if (acc) st_nx = ST_DATA;
                ST_DATA: if (word_done) st_nx = ST_WRITE;
                ST_WRITE: begin
                    if (wr_ack) begin
                        if (!last_word)      st_nx = ST_DATA;
                        else if (last_block) st_nx = ST_CRC0;
                        else                 st_nx = ST_HDR0;
                    end
                end
                ST_CRC0: if (acc) st_nx = ST_CRC1;
                ST_CRC1: if (acc) st_nx = ST_DONE;
                default: st_nx = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            crc_lo <= '0;
            done   <= 1'b0;
            error  <= 1'b0;
            abort  <= 1'b0;
        end else begin
            st <= st_nx;
            if (start) begin
                done  <= 1'b0;
                error <= 1'b0;
                abort <= 1'b0;
            end else if (acc) begin
                if ((st == ST_VER0 || st == ST_VER1) && bad_mark) begin
                    abort <= 1'b1;
                end
                if (st == ST_CRC0) begin
                    crc_lo <= in_data;
                end
                if (st == ST_CRC1) begin
                    done  <= 1'b1;
                    error <= ({in_data, crc_lo} != crc);
                end
            end
        end
    end

    cfg_ldr_crc16 i_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .en    (crc_en),
        .din   (in_data),
        .crc   (crc)
    );

    cfg_ldr_word_asm #(.WORD_W(DATA_W)) i_asm (
        .clk       (clk),
        .rst       (rst),
        .clear     (start),
        .take      (take),
        .din       (in_data),
        .narrow    (reg_narrow),
        .word      (wr_data),
        .narrow_q  (wr_byte),
        .word_done (word_done)
    );

    cfg_ldr_walker i_walk (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .cap        (cap),
        .sel        (sel),
        .din        (in_data),
        .step       (step),
        .addr       (addr),
        .last_word  (last_word),
        .last_block (last_block)
    );

    assign wr_en   = (st == ST_WRITE);
    assign wr_addr = {{(BUS_ADDR_W-ADDR_W){1'b0}}, addr};

endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        in_ready,
    input logic        wr_en,
    input logic [23:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        wr_byte,
    input logic        wr_ack,
    input logic        done,
    input logic        error,
    input logic        abort
);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!in_ready && !wr_en && !done && !error && !abort));

    p_abort_silent_r2: assert property (@(posedge clk) disable iff (rst)
        abort |-> (!wr_en && !in_ready && !done));

    p_addr_top_zero_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr[23:22] == 2'b00));

    p_narrow_zero_ext_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_byte) |-> (wr_data[31:8] == 24'h0));

    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ack && !start) |=>
            (wr_en && $stable(wr_addr) && $stable(wr_data) && $stable(wr_byte)));

    p_no_ready_in_write_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !in_ready);

    p_error_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(error) && !in_ready));

    p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !error && !abort));

    p_start_blocks_ready_r10: assert property (@(posedge clk) disable iff (rst)
        start |-> !in_ready);

endmodule

bind cfg_image_loader cfg_image_loader_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_byte  (wr_byte),
    .wr_ack   (wr_ack),
    .done     (done),
    .error    (error),
    .abort    (abort)
);

// File: tb/test_cfg_image_loader.sv
`timescale 1ns/1ps
module test_cfg_image_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        reg_narrow;
    logic        wr_en;
    logic [23:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_byte;
    logic        wr_ack = 1'b0;
    logic        done;
    logic        error;
    logic        abort;

    always #10 clk = ~clk;

    cfg_image_loader i_cfg_image_loader (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .reg_narrow (reg_narrow),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_byte    (wr_byte),
        .wr_ack     (wr_ack),
        .done       (done),
        .error      (error),
        .abort      (abort)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    function automatic logic narrow_at(input logic [23:0] a);
        return (a[2:0] == 3'b011);
    endfunction

    assign reg_narrow = narrow_at(wr_addr);

    typedef struct packed {
        logic [21:0] a0;
        logic [15:0] n;
        logic [31:0] seed;
    } blk_vec_t;

    localparam int NVEC = 3;
    localparam blk_vec_t VEC [NVEC] = '{
        '{a0: 22'h2ABC01, n: 16'd4, seed: 32'h11223344},
        '{a0: 22'h3FFFFE, n: 16'd3, seed: 32'hA0B0C0D0},
        '{a0: 22'h000013, n: 16'd1, seed: 32'h0BADF00D}
    };

    logic [7:0]  img[$];
    logic [23:0] exp_addr[$];
    logic [31:0] exp_data[$];
    logic        exp_nar[$];
    logic        exp_first[$];
    logic [23:0] rec_addr[$];
    logic [31:0] rec_data[$];
    logic        rec_nar[$];
    int          ack_lat = 0;
    int          ack_wait = 0;
    int          ready_viol = 0;
    int          accepted = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int upto);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < upto; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[15] ^ img[i][b];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic img_begin(input int nblocks);
        logic [15:0] cnt;
        img.delete(); exp_addr.delete(); exp_data.delete();
        exp_nar.delete(); exp_first.delete();
        cnt = 16'(nblocks - 1);
        img.push_back(8'hAA);
        img.push_back(8'hAA);
        img.push_back(cnt[7:0]);
        img.push_back(cnt[15:8]);
    endtask

    task automatic img_block(input logic [21:0] a0, input int n, input logic [31:0] seed);
        logic [9:0] m;
        m = 10'(n - 1);
        img.push_back(m[7:0]);
        img.push_back({a0[5:0], m[9:8]});
        img.push_back(a0[13:6]);
        img.push_back(a0[21:14]);
        for (int k = 0; k < n; k++) begin
            logic [21:0] a;
            logic [31:0] d;
            a = a0 + 22'(k);
            d = seed + 32'(k) * 32'h01030507;
            exp_addr.push_back({2'b00, a});
            exp_first.push_back(k == 0);
            if (narrow_at({2'b00, a})) begin
                img.push_back(d[7:0]);
                exp_data.push_back({24'h0, d[7:0]});
                exp_nar.push_back(1'b1);
            end else begin
                for (int j = 0; j < 4; j++) img.push_back(d[j*8 +: 8]);
                exp_data.push_back(d);
                exp_nar.push_back(1'b0);
            end
        end
    endtask

    task automatic img_end(input bit corrupt);
        logic [15:0] c;
        c = ref_crc(img.size());
        img.push_back(c[7:0] ^ {7'h0, corrupt});
        img.push_back(c[15:8]);
    endtask

    // write responder: acknowledges after ack_lat idle cycles
    always @(negedge clk) begin
        if (wr_en && in_ready) ready_viol++;
        if (wr_en && !wr_ack) begin
            if (ack_wait >= ack_lat) begin
                rec_addr.push_back(wr_addr);
                rec_data.push_back(wr_data);
                rec_nar.push_back(wr_byte);
                wr_ack <= 1'b1;
                ack_wait = 0;
            end else begin
                ack_wait++;
            end
        end else if (wr_ack) begin
            wr_ack <= 1'b0;
        end
    end

    task automatic clear_rec();
        rec_addr.delete(); rec_data.delete(); rec_nar.delete();
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ok);
        int w = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready && w < 20) begin
            @(negedge clk);
            w++;
        end
        ok = in_ready;
        if (ok) begin
            @(posedge clk);
            accepted++;
        end
    endtask

    task automatic stream(input int nbytes);
        bit ok;
        accepted = 0;
        for (int i = 0; i < nbytes; i++) begin
            send_byte(img[i], ok);
            if (!ok) break;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic compare_writes(input string tag);
        chk(rec_addr.size() == exp_addr.size(), "R3", {tag, " write count"},
            64'(rec_addr.size()), 64'(exp_addr.size()));
        for (int i = 0; i < exp_addr.size() && i < rec_addr.size(); i++) begin
            string rq;
            rq = exp_nar[i] ? "R7" : (exp_first[i] ? "R5" : "R6");
            chk(rec_addr[i] == exp_addr[i], rq, {tag, " addr"}, 64'(rec_addr[i]), 64'(exp_addr[i]));
            chk(rec_data[i] == exp_data[i], rq, {tag, " data"}, 64'(rec_data[i]), 64'(exp_data[i]));
            chk(rec_nar[i] == exp_nar[i], rq, {tag, " width flag"}, 64'(rec_nar[i]), 64'(exp_nar[i]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state and no acceptance before start
        chk(!in_ready, "R1", "in_ready after reset", 64'(in_ready), 0);
        chk(!wr_en, "R1", "wr_en after reset", 64'(wr_en), 0);
        chk(!done && !error, "R1", "done/error after reset", 64'({done, error}), 0);
        chk(!abort, "R1", "abort after reset", 64'(abort), 0);
        in_valid = 1'b1;
        in_data  = 8'hAA;
        repeat (8) @(negedge clk);
        chk(!in_ready, "R1", "in_ready before start", 64'(in_ready), 0);
        in_valid = 1'b0;

        // Main table-driven image, slow acknowledge
        ack_lat = 2;
        img_begin(NVEC);
        for (int v = 0; v < NVEC; v++) img_block(VEC[v].a0, int'(VEC[v].n), VEC[v].seed);
        img_end(1'b0);
        clear_rec();
        pulse_start();
        stream(img.size());
        compare_writes("table image");
        chk(done == 1'b1, "R9", "done after good image", 64'(done), 1);
        chk(error == 1'b0, "R9", "error after good image", 64'(error), 0);
        chk(!in_ready, "R9", "in_ready after done", 64'(in_ready), 0);
        chk(accepted == img.size(), "R3", "bytes consumed", 64'(accepted), 64'(img.size()));
        chk(ready_viol == 0, "R8", "ready during write", 64'(ready_viol), 0);

        // Same image, bad checksum, immediate acknowledge
        ack_lat = 0;
        img.delete();
        img_begin(NVEC);
        for (int v = 0; v < NVEC; v++) img_block(VEC[v].a0, int'(VEC[v].n), VEC[v].seed);
        img_end(1'b1);
        clear_rec();
        pulse_start();
        chk(!done && !error, "R10", "start clears done/error", 64'({done, error}), 0);
        stream(img.size());
        compare_writes("bad crc image");
        chk(done && error, "R9", "done+error on bad crc", 64'({done, error}), 64'(2'b11));

        // Bad first marker byte
        img_begin(1);
        img[0] = 8'h55;
        img_block(22'h000100, 2, 32'h12345678);
        img_end(1'b0);
        clear_rec();
        pulse_start();
        stream(img.size());
        chk(abort == 1'b1, "R2", "abort on bad byte 0", 64'(abort), 1);
        chk(done == 1'b0, "R2", "done on bad byte 0", 64'(done), 0);
        chk(rec_addr.size() == 0, "R2", "writes on bad byte 0", 64'(rec_addr.size()), 0);
        chk(accepted == 1, "R2", "bytes taken on bad byte 0", 64'(accepted), 1);

        // Bad second marker byte
        img[0] = 8'hAA;
        img[1] = 8'hAB;
        clear_rec();
        pulse_start();
        chk(abort == 1'b0, "R10", "start clears abort", 64'(abort), 0);
        stream(img.size());
        chk(abort == 1'b1, "R2", "abort on bad byte 1", 64'(abort), 1);
        chk(accepted == 2, "R2", "bytes taken on bad byte 1", 64'(accepted), 2);
        chk(rec_addr.size() == 0, "R2", "writes on bad byte 1", 64'(rec_addr.size()), 0);

        // Restart in the middle of a load
        ack_lat = 1;
        img_begin(NVEC);
        for (int v = 0; v < NVEC; v++) img_block(VEC[v].a0, int'(VEC[v].n), VEC[v].seed);
        img_end(1'b0);
        pulse_start();
        stream(14);
        clear_rec();
        pulse_start();
        stream(img.size());
        compare_writes("restart");
        chk(done && !error, "R10", "restart completes clean", 64'({done, error}), 64'(2'b10));

        // Long block exercising the split word count
        ack_lat = 0;
        img_begin(1);
        img_block(22'h000100, 257, 32'h5A000000);
        img_end(1'b0);
        clear_rec();
        pulse_start();
        stream(img.size());
        chk(rec_addr.size() == 257, "R4", "long block writes", 64'(rec_addr.size()), 257);
        if (rec_addr.size() == 257)
            chk(rec_addr[256] == 24'h000200, "R4", "long block last addr", 64'(rec_addr[256]), 64'h200);
        compare_writes("long block");
        chk(done && !error, "R9", "long block checksum", 64'({done, error}), 64'(2'b10));
        chk(ready_viol == 0, "R8", "ready during write, all runs", 64'(ready_viol), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule